// File: doc/BRIEF.md
# Low-Transition Bit-Swapping Pattern Generator

This block produces pseudorandom test patterns for built-in self-test. It contains a maximal-length Fibonacci shift register of `STAGES` cells, with feedback taken from a tap mask parameter. Its visible outputs pass through a row of 2-to-1 multiplexers. The last cell drives the select line of every multiplexer. When that cell is 0, each pair of directly connected cells reaches the outputs unchanged. When it is 1, the two cells of each pair trade places. The output words are therefore the same nonzero words the plain register would give, in a different order. That order has fewer bit changes between consecutive words.

The parallel word is meant for test-per-clock use, where it drives the primary inputs of a circuit under test. A single serial bit is meant for feeding a scan chain. A seed can be loaded at any time. A separate enable advances the sequence, so the block can pause between patterns.

Top module: `bslfsr_top`

## Requirements
- R1: When `step_i` is 1 and `load_i` is 0, the register advances one position per clock. Cell c(i+1) takes the old value of cell c(i), where state bit 0 is c1 and bit STAGES-1 is cn. Cell c1 takes the XOR of every cell whose `TAP_MASK` bit is set.
- R2: Starting from any nonzero state, the state returns to that same value after exactly 2^STAGES-1 steps, and not earlier. It is never all zeros.
- R3: When `load_i` is 1 and `seed_i` is nonzero, the next state equals `seed_i`. A load overrides `step_i` in the same cycle.
- R4: A load with an all-zero `seed_i` sets the state to 1, meaning only c1 is set.
- R5: When both `load_i` and `step_i` are 0, the state and both outputs hold.
- R6: Bit STAGES-1 of `par_o` is cn. For each pair (c(2k+1), c(2k+2)), mapped to `par_o` bits 2k and 2k+1, the cells pass straight through when cn is 0 and are exchanged when cn is 1. If STAGES-1 is odd, bit STAGES-2 passes straight through.
- R7: Over one period, the parallel words are exactly the 2^STAGES-1 distinct nonzero values.
- R8: `ser_o` equals bit 0 of `par_o`. That is c1 when cn is 0 and c2 when cn is 1.
- R9: While reset is asserted and after its release, the state is 1. So `par_o` is 1 and `ser_o` is 1.
- R10: Over one period, every bit of `par_o` is 1 in exactly 2^(STAGES-1) words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Load `seed_i` into the register |
| seed_i | input | STAGES | Seed value |
| step_i | input | 1 | Advance the sequence one step |
| par_o | output | STAGES | Swapped parallel pattern |
| ser_o | output | 1 | Serial pattern bit for a scan input |

## Verification
Load and step can be requested in the same cycle. The sweep provokes this on purpose: every seed is applied with `step_i` held at 1. The result is judged by checking that the next word is the swapped image of the seed itself and not of its successor. A load of zero and a load while paused are checked the same way. The full sweep over all 31 seeds of the 5-stage default also checks the period, the set of words and the bit balance.

// File: rtl/bslfsr_pkg.sv
package bslfsr_pkg;
    localparam int unsigned DEF_STAGES = 5;
    localparam logic [31:0] DEF_TAPS   = 32'h0000_0014;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_STEP = 2'd1,
        ACT_LOAD = 2'd2
    } act_e;
endpackage

// File: rtl/bslfsr_core.sv
module bslfsr_core #(
    parameter int unsigned        STAGES   = 5,
    parameter logic [STAGES-1:0]  TAP_MASK = 5'b10100
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [STAGES-1:0] seed_i,
    input  logic              step_i,
    output logic [STAGES-1:0] cells_o
);
    import bslfsr_pkg::*;

    localparam logic [STAGES-1:0] ONE_STATE = {{(STAGES-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [STAGES-1:0] cells;
    } core_s;

    core_s cur_q, nxt_d;
    act_e  act;
    logic  fb;

    always_comb begin
        nxt_d = cur_q;
        fb    = ^(cur_q.cells & TAP_MASK);
        if (load_i)      act = ACT_LOAD;
        else if (step_i) act = ACT_STEP;
        else             act = ACT_HOLD;
        case (act)
            ACT_LOAD: nxt_d.cells = (seed_i == '0) ? ONE_STATE : seed_i;
            ACT_STEP: nxt_d.cells = {cur_q.cells[STAGES-2:0], fb};
            default:  nxt_d.cells = cur_q.cells;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cur_q.cells <= ONE_STATE;
        else         cur_q       <= nxt_d;
    end

    assign cells_o = cur_q.cells;

    AST_NEVER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cur_q.cells != '0); // R2
    AST_SEED_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && seed_i != '0) |=> cur_q.cells == $past(seed_i)); // R3
    AST_ZERO_SEED_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && seed_i == '0) |=> cur_q.cells == ONE_STATE); // R4
    AST_PAUSE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && !step_i) |=> $stable(cur_q.cells)); // R5
    AST_SHIFT_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && step_i) |=> cur_q.cells[STAGES-1:1] == $past(cur_q.cells[STAGES-2:0])); // R1
endmodule

// File: rtl/bslfsr_swap.sv
module bslfsr_swap #(
    parameter int unsigned STAGES = 5
) (
    input  logic [STAGES-1:0] cells_i,
    output logic [STAGES-1:0] par_o
);
    localparam int unsigned PAIRS = (STAGES - 1) / 2;
    localparam bit          ODD   = ((STAGES - 1) % 2) != 0;

    logic sel;
    assign sel = cells_i[STAGES-1];

    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
        assign par_o[2*k]   = sel ? cells_i[2*k+1] : cells_i[2*k];
        assign par_o[2*k+1] = sel ? cells_i[2*k]   : cells_i[2*k+1];
    end

    if (ODD) begin : g_left
        assign par_o[STAGES-2] = cells_i[STAGES-2];
    end

    assign par_o[STAGES-1] = sel;

    always_comb begin
        if (!$isunknown(cells_i)) begin
            AST_WEIGHT_KEPT: assert ($countones(par_o) == $countones(cells_i)); // R6
        end
    end
endmodule

// File: rtl/bslfsr_top.sv
module bslfsr_top #(
    parameter int unsigned       STAGES   = bslfsr_pkg::DEF_STAGES,
    parameter logic [STAGES-1:0] TAP_MASK = STAGES'(bslfsr_pkg::DEF_TAPS)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [STAGES-1:0] seed_i,
    input  logic              step_i,
    output logic [STAGES-1:0] par_o,
    output logic              ser_o
);
    logic [STAGES-1:0] cells;

    bslfsr_core #(.STAGES(STAGES), .TAP_MASK(TAP_MASK)) u_core (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (load_i),
        .seed_i  (seed_i),
        .step_i  (step_i),
        .cells_o (cells)
    );

    bslfsr_swap #(.STAGES(STAGES)) u_swap (
        .cells_i (cells),
        .par_o   (par_o)
    );

    assign ser_o = par_o[0];

    AST_SERIAL_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ser_o == (cells[STAGES-1] ? cells[1] : cells[0])); // R8
endmodule

// File: tb/bslfsr_top_tb_top.sv
module bslfsr_top_tb_top;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned N          = 5;
    localparam logic [N-1:0] TAPS      = 5'b10100;
    localparam int unsigned PERIOD     = (1 << N) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load = 1'b0;
    logic [N-1:0] seed = '0;
    logic         step = 1'b0;
    logic [N-1:0] par;
    logic         ser;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bslfsr_top #(.STAGES(N), .TAP_MASK(TAPS)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .load_i(load), .seed_i(seed),
        .step_i(step), .par_o(par), .ser_o(ser)
    );

    function automatic logic [N-1:0] model_next(input logic [N-1:0] s);
        return {s[N-2:0], ^(s & TAPS)};
    endfunction

    function automatic logic [N-1:0] model_par(input logic [N-1:0] s);
        logic [N-1:0] p = s;
        if (s[N-1]) begin
            for (int k = 0; k < (N-1)/2; k++) begin
                p[2*k]   = s[2*k+1];
                p[2*k+1] = s[2*k];
            end
        end
        return p;
    endfunction

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // caller stands at a falling edge; outputs are sampled at the next one
    task automatic tick(input logic ld, input logic [N-1:0] sd, input logic st);
        load = ld; seed = sd; step = st;
        @(negedge clk);
        load = 1'b0; step = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            done = 1'b1;
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected=<50000", cycles);
            report();
        end
    end

    initial begin
        logic [N-1:0] m;
        logic [N-1:0] start;
        bit [(1<<N)-1:0] seen;
        int ones [N];
        int ret_at;
        int distinct;

        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 reset par", par, 5'b00001);
        check("R9 reset ser", {4'b0, ser}, 5'b00001);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 after release", par, 5'b00001);

        // R5: paused cycles
        tick(1'b0, '0, 1'b0);
        tick(1'b0, '0, 1'b0);
        check("R5 hold after reset", par, 5'b00001);

        // R6 literal encodings
        tick(1'b1, 5'b10110, 1'b0);
        check("R6 swapped when cn=1", par, 5'b11001);
        tick(1'b0, '0, 1'b0);
        check("R5 hold loaded", par, 5'b11001);
        tick(1'b1, 5'b01101, 1'b0);
        check("R6 straight when cn=0", par, 5'b01101);

        // R4 zero seed
        tick(1'b1, 5'b00000, 1'b1);
        check("R4 zero seed", par, 5'b00001);

        for (int sv = 1; sv <= PERIOD; sv++) begin
            tick(1'b1, N'(sv), 1'b1);
            check("R3 load overrides step", par, model_par(N'(sv)));
            m = N'(sv);
            start = par;
            seen = '0;
            for (int b = 0; b < N; b++) ones[b] = 0;
            ret_at = 0;
            for (int j = 1; j <= PERIOD; j++) begin
                seen[par] = 1'b1;
                for (int b = 0; b < N; b++) ones[b] += int'(par[b]);
                tick(1'b0, '0, 1'b1);
                m = model_next(m);
                check("R1 R6 step", par, model_par(m));
                check("R8 serial", {4'b0, ser}, {4'b0, model_par(m)[0]});
                if (par == start && ret_at == 0) ret_at = j;
            end
            checks++;
            if (ret_at != PERIOD) begin
                failures++;
                $display("FAIL R2 period actual=%0d expected=%0d", ret_at, PERIOD);
            end
            distinct = $countones(seen);
            checks++;
            if (distinct != PERIOD || seen[0]) begin
                failures++;
                $display("FAIL R7 set actual=%0d zero=%0d expected=%0d zero=0", distinct, seen[0], PERIOD);
            end
            for (int b = 0; b < N; b++) begin
                checks++;
                if (ones[b] != (1 << (N-1))) begin
                    failures++;
                    $display("FAIL R10 bit%0d ones actual=%0d expected=%0d", b, ones[b], 1 << (N-1));
                end
            end
        end

        // R5 pause mid-sequence
        tick(1'b0, '0, 1'b1);
        start = par;
        tick(1'b0, '0, 1'b0);
        tick(1'b0, '0, 1'b0);
        check("R5 pause mid-run", par, start);

        done = 1'b1;
        report();
    end
endmodule